// File: doc/BRIEF.md
# Multiplexed LED Matrix Scanner with Global PWM Dimming

This block drives a time-multiplexed LED matrix from a display memory that holds four pixels per word. The matrix has two geometries. In the narrow geometry there are 32 row lines and 8 common lines. In the tall geometry there are 24 row lines and 16 common lines, and the top eight row pins serve as the extra commons. The scanner enables one common at a time, in ascending order. For each common it shows that column of pixels on the row lines.

While the current common is on display, a four-state fetch machine reads the next common's column from the memory, one word per cycle. It keeps that column in a shadow register until the slot boundary, so a column never changes partway through a slot. The states are IDLE, FILL, DRAIN and HOLD. Every common slot is split into 16 equal PWM steps, and a global 4-bit level sets how many of those steps are lit. The outputs go blank when the system enable or the LED enable is low. An optional blink gate blanks the whole display for alternate equal half-periods.

The fetch machine moves between its states as follows:
- IDLE to FILL (start) when both enables rise.
- FILL to DRAIN (last_row) after the last row address has been issued.
- DRAIN to HOLD (captured) once the final word has been stored.
- HOLD to FILL (swap) either at once on the first column or at the end of the current slot. On a swap the shadow column moves to the display and the next common is selected.
- Any state returns to IDLE (stop) whenever either enable is low.

Top module: `led_scan_top`

## Requirements
- R1: With the 8-common geometry, row n lit on common c shows bit c[1:0] of the memory word at address 2n + c[2]. Bit 0 of each word belongs to the lowest common held in that word.
- R2: With the 16-common geometry, row n (0..23) lit on common c shows bit c[1:0] of the word at address 4n + c[3:2].
- R3: With the 16-common geometry, row pin 24+j acts as common 15-j. Pin 24 is common 15 and pin 31 is common 8. These pins never carry pixel data in that geometry.
- R4: At most one common is active at any time. The commons are visited in ascending order and wrap after the last one, and every common appears in each frame.
- R5: With level k, each common slot is lit for (k+1)/16 of its length (k+1 of 16 steps). Level 15 lights the whole slot.
- R6: When sys_en or led_en is low, every row and common output sits at its inactive level from the next clock edge on.
- R7: With blink_en high, the display alternates lit and dark phases, each BLINK_TICKS cycles long, so lit time is exactly half of any whole number of blink periods.
- R8: The geometry select is taken only while the scan is disabled. A change to com16_sel during scanning has no effect on the outputs.
- R9: During and after reset, until scanning is enabled, all outputs are at their inactive level. That level is 0 when ACTIVE_HIGH is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System enable; low stops the scan |
| led_en | input | 1 | LED output enable; low stops the scan |
| blink_en | input | 1 | Enable global blinking |
| com16_sel | input | 1 | 1 selects 24 rows x 16 commons, 0 selects 32 rows x 8 commons |
| pwm_level | input | 4 | Global brightness, lit steps = level + 1 |
| ram_rdata | input | 4 | Display memory read data, one cycle after address |
| ram_raddr | output | 7 | Display memory read address |
| row_drv | output | 32 | Row line drive; pins 31..24 are commons 8..15 in 16-common geometry |
| com_drv | output | 8 | Common lines 0..7 |

## Verification
The hardest case to reach from the ports is a change to the geometry select while scanning is running. It has to be shown to do nothing, and then shown to take effect after a disable. The stimulus runs a scan in the 8-common geometry and raises com16_sel partway through. It then checks a whole frame against the 8-common mapping. Next it drops led_en and raises it again, and checks the following frame against the 16-common mapping with shared pins. Brightness and blink are measured by counting lit cycles over windows whose length is a whole number of slot or blink periods, so the count is exact whatever the starting phase.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
    localparam int NIB_W   = 4;
    localparam int COM_W   = 4;
    localparam int COMS8   = 8;
    localparam int COMS16  = 16;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_FILL  = 2'd1,
        F_DRAIN = 2'd2,
        F_HOLD  = 2'd3
    } fetch_state_t;
endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
    parameter int SLOT8_TICKS  = 320,
    parameter int SLOT16_TICKS = 160,
    parameter int BLINK_TICKS  = 64000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_en,
    input  logic       run,
    input  logic       blink_en,
    input  logic       mode16,
    output logic       slot_end,
    output logic [3:0] step,
    output logic       blink_on
);
    localparam int STEP8   = SLOT8_TICKS / 16;
    localparam int STEP16  = SLOT16_TICKS / 16;
    localparam int STEPMAX = (STEP8 > STEP16) ? STEP8 : STEP16;
    localparam int SUB_W   = $clog2(STEPMAX) + 1;
    localparam int BL_W    = $clog2(BLINK_TICKS) + 1;

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] step_last;
    logic [BL_W-1:0]  blink_q;
    logic             sub_wrap;

    assign step_last = mode16 ? SUB_W'(STEP16 - 1) : SUB_W'(STEP8 - 1);
    assign sub_wrap  = (sub_q == step_last);
    assign slot_end  = scan_en && sub_wrap && (step == 4'hF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            step  <= '0;
        end else if (!scan_en) begin
            sub_q <= '0;
            step  <= '0;
        end else if (sub_wrap) begin
            sub_q <= '0;
            step  <= step + 4'd1;
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blink_q  <= '0;
            blink_on <= 1'b1;
        end else if (!(run && blink_en)) begin
            blink_q  <= '0;
            blink_on <= 1'b1;
        end else if (blink_q == BL_W'(BLINK_TICKS - 1)) begin
            blink_q  <= '0;
            blink_on <= ~blink_on;
        end else begin
            blink_q <= blink_q + BL_W'(1);
        end
    end
endmodule

// File: rtl/led_scan_fetch.sv
module led_scan_fetch
    import led_scan_pkg::*;
#(
    parameter int ROWS8  = 32,
    parameter int ROWS16 = 24,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode16,
    input  logic              slot_end,
    input  logic [NIB_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [ROWS8-1:0]  disp_col,
    output logic [COM_W-1:0]  disp_com,
    output logic              showing,
    output fetch_state_t      state
);
    localparam int ROW_W = $clog2(ROWS8);

    fetch_state_t       state_nxt;
    logic [ROW_W-1:0]   row_q;
    logic [ROW_W-1:0]   row_last;
    logic [COM_W-1:0]   fcom_q;
    logic [COM_W-1:0]   fcom_next;
    logic [ROWS8-1:0]   shadow_q;
    logic               cap_valid;
    logic [ROW_W-1:0]   cap_row;
    logic [1:0]         cap_bit;
    logic               do_swap;

    assign row_last  = mode16 ? ROW_W'(ROWS16 - 1) : ROW_W'(ROWS8 - 1);
    assign fcom_next = mode16 ? fcom_q + COM_W'(1) : {1'b0, fcom_q[2:0] + 3'd1};
    assign ram_raddr = mode16 ? ADDR_W'({row_q, fcom_q[3:2]})
                              : ADDR_W'({row_q, fcom_q[2]});
    assign do_swap   = (state == F_HOLD) && (!showing || slot_end);

    always_comb begin
        state_nxt = state;
        unique case (state)
            F_IDLE:  if (run) state_nxt = F_FILL;
            F_FILL:  if (row_q == row_last) state_nxt = F_DRAIN;
            F_DRAIN: state_nxt = F_HOLD;
            F_HOLD:  if (do_swap) state_nxt = F_FILL;
            default: state_nxt = F_IDLE;
        endcase
        if (!run) state_nxt = F_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q     <= '0;
            fcom_q    <= '0;
            shadow_q  <= '0;
            cap_valid <= 1'b0;
            cap_row   <= '0;
            cap_bit   <= '0;
            disp_col  <= '0;
            disp_com  <= '0;
            showing   <= 1'b0;
        end else begin
            cap_valid <= run && (state == F_FILL);
            cap_row   <= row_q;
            cap_bit   <= fcom_q[1:0];
            if (cap_valid) shadow_q[cap_row] <= ram_rdata[cap_bit];
            if (!run || state == F_IDLE) begin
                row_q   <= '0;
                fcom_q  <= '0;
                showing <= 1'b0;
            end else if (state == F_FILL) begin
                row_q <= row_q + ROW_W'(1);
            end else if (do_swap) begin
                disp_col <= shadow_q;
                disp_com <= fcom_q;
                showing  <= 1'b1;
                fcom_q   <= fcom_next;
                row_q    <= '0;
            end
        end
    end
endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive
    import led_scan_pkg::*;
#(
    parameter int ROWS8       = 32,
    parameter int ROWS16      = 24,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              showing,
    input  logic              blink_on,
    input  logic [3:0]        step,
    input  logic [3:0]        level,
    input  logic              mode16,
    input  logic [ROWS8-1:0]  disp_col,
    input  logic [COM_W-1:0]  disp_com,
    output logic [ROWS8-1:0]  row_drv,
    output logic [COMS8-1:0]  com_drv
);
    localparam logic INV = ~ACTIVE_HIGH;

    logic              lit;
    logic [COMS16-1:0] com_vec;
    logic [ROWS8-1:0]  row_nxt;

    assign lit     = run && showing && blink_on && (step <= level);
    assign com_vec = lit ? (COMS16'(1) << disp_com) : '0;

    for (genvar n = 0; n < ROWS8; n++) begin : g_row
        if (n < ROWS16) begin : g_pix
            assign row_nxt[n] = disp_col[n] & lit;
        end else begin : g_shared
            assign row_nxt[n] = mode16 ? com_vec[COMS16 - 1 - (n - ROWS16)]
                                       : (disp_col[n] & lit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_drv <= {ROWS8{INV}};
            com_drv <= {COMS8{INV}};
        end else begin
            row_drv <= row_nxt ^ {ROWS8{INV}};
            com_drv <= com_vec[COMS8-1:0] ^ {COMS8{INV}};
        end
    end
endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
    import led_scan_pkg::*;
#(
    parameter int SLOT8_TICKS  = 320,
    parameter int SLOT16_TICKS = 160,
    parameter int BLINK_TICKS  = 64000,
    parameter bit ACTIVE_HIGH  = 1'b1,
    parameter int ADDR_W       = 7,
    parameter int ROWS8        = 32,
    parameter int ROWS16       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_en,
    input  logic              led_en,
    input  logic              blink_en,
    input  logic              com16_sel,
    input  logic [3:0]        pwm_level,
    input  logic [NIB_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [ROWS8-1:0]  row_drv,
    output logic [COMS8-1:0]  com_drv
);
    logic               run;
    logic               mode_q;
    logic               slot_end;
    logic [3:0]         step;
    logic               blink_on;
    logic               showing;
    logic [ROWS8-1:0]   disp_col;
    logic [COM_W-1:0]   disp_com;
    fetch_state_t       fstate;

    assign run = sys_en && led_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mode_q <= 1'b0;
        else if (!run) mode_q <= com16_sel;
    end

    led_scan_timer #(
        .SLOT8_TICKS (SLOT8_TICKS),
        .SLOT16_TICKS(SLOT16_TICKS),
        .BLINK_TICKS (BLINK_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (run && showing),
        .run     (run),
        .blink_en(blink_en),
        .mode16  (mode_q),
        .slot_end(slot_end),
        .step    (step),
        .blink_on(blink_on)
    );

    led_scan_fetch #(
        .ROWS8 (ROWS8),
        .ROWS16(ROWS16),
        .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode16   (mode_q),
        .slot_end (slot_end),
        .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr),
        .disp_col (disp_col),
        .disp_com (disp_com),
        .showing  (showing),
        .state    (fstate)
    );

    led_scan_drive #(
        .ROWS8      (ROWS8),
        .ROWS16     (ROWS16),
        .ACTIVE_HIGH(ACTIVE_HIGH)
    ) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .showing (showing),
        .blink_on(blink_on),
        .step    (step),
        .level   (pwm_level),
        .mode16  (mode_q),
        .disp_col(disp_col),
        .disp_com(disp_com),
        .row_drv (row_drv),
        .com_drv (com_drv)
    );
endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker
    import led_scan_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sys_en,
    input logic         led_en,
    input logic         mode_q,
    input logic         showing,
    input logic         slot_end,
    input logic [3:0]   step,
    input logic [3:0]   pwm_level,
    input fetch_state_t fstate,
    input logic [31:0]  row_drv,
    input logic [7:0]   com_drv
);
    logic [31:0] row_act;
    logic [7:0]  com_act;
    logic [15:0] act;

    assign row_act = ACTIVE_HIGH ? row_drv : ~row_drv;
    assign com_act = ACTIVE_HIGH ? com_drv : ~com_drv;
    assign act     = mode_q ? {row_act[24], row_act[25], row_act[26], row_act[27],
                               row_act[28], row_act[29], row_act[30], row_act[31], com_act}
                            : {8'h00, com_act};

    // R4: never two commons at once
    a_r4_one_common: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    // R4: next column is ready whenever a slot ends
    a_r4_fill_before_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |-> (fstate == F_HOLD));

    // R5: steps above the level stay dark
    a_r5_dark_above_level: assert property (@(posedge clk) disable iff (!rst_n)
        (showing && step > pwm_level) |=> (row_act == 32'h0 && com_act == 8'h0));

    // R6: blank when either enable is low
    a_r6_blank_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_en && led_en) |=> (row_act == 32'h0 && com_act == 8'h0));

    // R8: geometry frozen while scanning
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && led_en) |=> $stable(mode_q));
endmodule

bind led_scan_top led_scan_checker #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_en   (sys_en),
    .led_en   (led_en),
    .mode_q   (mode_q),
    .showing  (showing),
    .slot_end (slot_end),
    .step     (step),
    .pwm_level(pwm_level),
    .fstate   (fstate),
    .row_drv  (row_drv),
    .com_drv  (com_drv)
);

// File: tb/led_scan_top_tb.sv
module led_scan_top_tb;
    localparam int SLOT8  = 64;
    localparam int SLOT16 = 48;
    localparam int BLINK  = 200;
    localparam int STEP8  = SLOT8 / 16;
    localparam int STEP16 = SLOT16 / 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_en = 1'b0;
    logic        led_en = 1'b0;
    logic        blink_en = 1'b0;
    logic        com16_sel = 1'b0;
    logic [3:0]  pwm_level = 4'hF;
    logic [3:0]  ram_rdata;
    logic [6:0]  ram_raddr;
    logic [31:0] row_drv;
    logic [7:0]  com_drv;

    logic [3:0]  mem [128];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) ram_rdata <= mem[ram_raddr];

    led_scan_top #(
        .SLOT8_TICKS (SLOT8),
        .SLOT16_TICKS(SLOT16),
        .BLINK_TICKS (BLINK)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_en   (sys_en),
        .led_en   (led_en),
        .blink_en (blink_en),
        .com16_sel(com16_sel),
        .pwm_level(pwm_level),
        .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr),
        .row_drv  (row_drv),
        .com_drv  (com_drv)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 128; i++) mem[i] = 4'((i * seed + 3) ^ (i >> 2));
    endtask

    function automatic logic exp_bit(input int n, input int c, input bit m16);
        logic [3:0] w;
        w = m16 ? mem[4 * n + c / 4] : mem[2 * n + c / 4];
        return w[c % 4];
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Observe the outputs for a window; count lit cycles, mapping errors,
    // ordering errors and the set of commons seen.
    task automatic scan(input int window, input bit m16, output int lit,
                        output int bad, output int seqbad, output int seen);
        int last_c;
        int ncom;
        last_c = -1;
        ncom = m16 ? 16 : 8;
        lit = 0; bad = 0; seqbad = 0; seen = 0;
        for (int t = 0; t < window; t++) begin
            logic [15:0] act;
            int cnt;
            int c;
            @(negedge clk);
            act = {8'h00, com_drv};
            if (m16) for (int k = 0; k < 8; k++) act[8 + k] = row_drv[31 - k];
            cnt = $countones(act);
            c = -1;
            for (int k = 0; k < 16; k++) if (act[k]) c = k;
            if (cnt > 1) bad++;
            if (cnt == 1) begin
                lit++;
                seen = seen | (1 << c);
                for (int n = 0; n < (m16 ? 24 : 32); n++)
                    if (row_drv[n] !== exp_bit(n, c, m16)) bad++;
                if (last_c >= 0 && c != last_c && c != (last_c + 1) % ncom) seqbad++;
                last_c = c;
            end else if (cnt == 0) begin
                if ((m16 ? {8'h00, row_drv[23:0]} : row_drv) != 32'h0) bad++;
            end
        end
    endtask

    task automatic t_reset;
        wait_cycles(2);
        check("R9 rows in reset", int'(row_drv), 0);
        check("R9 commons in reset", int'(com_drv), 0);
        rst_n = 1'b1;
        wait_cycles(20);
        check("R9 rows idle after reset", int'(row_drv), 0);
        check("R9 commons idle after reset", int'(com_drv), 0);
    endtask

    task automatic t_map8;
        int lit, bad, sq, seen;
        fill_mem(7);
        com16_sel = 1'b0; pwm_level = 4'hF;
        sys_en = 1'b1; led_en = 1'b1;
        wait_cycles(200);
        scan(8 * SLOT8, 1'b0, lit, bad, sq, seen);
        check("R1 8-common pixel mapping", bad, 0);
        check("R4 8-common order", sq, 0);
        check("R4 all 8 commons seen", seen, 32'hFF);
        check("R5 level 15 fully lit", lit, 8 * SLOT8);
    endtask

    task automatic t_pwm8;
        int lit, bad, sq, seen;
        pwm_level = 4'd3;
        wait_cycles(SLOT8);
        scan(8 * SLOT8, 1'b0, lit, bad, sq, seen);
        check("R5 level 3 lit cycles", lit, 8 * 4 * STEP8);
        check("R1 mapping at level 3", bad, 0);
        pwm_level = 4'd0;
        wait_cycles(SLOT8);
        scan(8 * SLOT8, 1'b0, lit, bad, sq, seen);
        check("R5 level 0 lit cycles", lit, 8 * 1 * STEP8);
        pwm_level = 4'hF;
    endtask

    task automatic t_mode_locked;
        int lit, bad, sq, seen;
        fill_mem(11);
        com16_sel = 1'b1;
        wait_cycles(2 * 8 * SLOT8);
        scan(8 * SLOT8, 1'b0, lit, bad, sq, seen);
        check("R8 mapping stays 8-common", bad, 0);
        check("R8 commons stay 8", seen, 32'hFF);
        check("R8 lit stays full", lit, 8 * SLOT8);
    endtask

    task automatic t_blank;
        int nz;
        led_en = 1'b0;
        wait_cycles(2);
        nz = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (row_drv != 0 || com_drv != 0) nz++;
        end
        check("R6 blank with led_en low", nz, 0);
        led_en = 1'b1; sys_en = 1'b0;
        wait_cycles(2);
        nz = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (row_drv != 0 || com_drv != 0) nz++;
        end
        check("R6 blank with sys_en low", nz, 0);
    endtask

    task automatic t_map16;
        int lit, bad, sq, seen;
        fill_mem(5);
        sys_en = 1'b1;
        wait_cycles(300);
        scan(16 * SLOT16, 1'b1, lit, bad, sq, seen);
        check("R2 16-common pixel mapping", bad, 0);
        check("R3 shared pins as commons 8..15", seen, 32'hFFFF);
        check("R4 16-common order", sq, 0);
        check("R5 16-common full lit", lit, 16 * SLOT16);
        pwm_level = 4'd7;
        wait_cycles(SLOT16);
        scan(16 * SLOT16, 1'b1, lit, bad, sq, seen);
        check("R5 16-common level 7 lit", lit, 16 * 8 * STEP16);
        check("R3 mapping at level 7", bad, 0);
        pwm_level = 4'hF;
    endtask

    task automatic t_blink;
        int lit, bad, sq, seen;
        blink_en = 1'b1;
        wait_cycles(50);
        scan(4 * BLINK, 1'b1, lit, bad, sq, seen);
        check("R7 blink half lit", lit, 2 * BLINK);
        check("R7 mapping while blinking", bad, 0);
        blink_en = 1'b0;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        fill_mem(3);
        t_reset();
        t_map8();
        t_pwm8();
        t_mode_locked();
        t_blank();
        t_map16();
        t_blink();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule